// File: doc/BRIEF.md
# Programmable Bit-Field Left Shifter with Carry

This block shifts a variable-length bit field toward its most significant end in a single registered step. The field always starts at bit 0 of a `W`-bit data word and spans `n1` bits. When `start` is pulsed, the lowest `n1` bits move left by an effective amount. That amount is the shift count `n2` reduced modulo `n1`. The vacated low positions are loaded with zeros. The last bit to leave the top of the field is captured in a carry flag. Bits at position `n1` and above pass through untouched.

The parameters are checked before any shift takes place. An out-of-range length or a negative count gives error code 4100. A length larger than the caller's destination capacity (`dst_bits`) gives error code 4101. Several zero conditions turn the request into a no-op: a zero length, a zero count, or a count that is a whole multiple of the length. Every request, whatever its outcome, is answered by a one-cycle `done` pulse on the cycle after `start`. All results are registered.

Top module: `shl_bitfield_carry`

## Requirements
- R1: If `n1` exceeds `W` or `n2` is negative, the block sets `err`, sets `err_code` to 4100, returns `dout` equal to `din` and keeps `carry`. This check takes priority over R2.
- R2: If R1 does not apply and `n1` exceeds `dst_bits`, the block sets `err`, sets `err_code` to 4101, returns `dout` equal to `din` and keeps `carry`.
- R3: If no error applies and `n1` or `n2` is zero, `dout` equals `din`, `carry` is unchanged and `err` is low.
- R4: The effective shift `s` is `n2 mod n1`. If `s` is 0, the request behaves as the no-op of R3.
- R5: For a valid request with `s` > 0, `dout[i]` equals `din[i-s]` for `s` <= i < `n1`, and `dout[i]` is 0 for i < `s`.
- R6: `dout[i]` equals `din[i]` for every i >= `n1`, in every case.
- R7: For a valid request with `s` > 0, `carry` becomes `din[n1-s]`.
- R8: `done` is high for exactly the one cycle after each cycle in which `start` is high, and only then.
- R9: After synchronous reset, `dout`, `carry`, `done`, `err` and `err_code` are all 0.
- R10: After any request that raises no error, `err` is 0 and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, one cycle |
| din | input | W | Data word holding the field at bits [n1-1:0] |
| n1 | input | N1W | Field length in bits, unsigned |
| n2 | input | N2W | Shift count, two's complement |
| dst_bits | input | N1W | Bit capacity of the destination |
| dout | output | W | Registered result word |
| carry | output | 1 | Last bit pushed out of the field |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| err_code | output | 16 | 4100, 4101, or 0 when there was no error |

## Verification
The bench targets these corner cases:
- **Full-width field (`n1` = `W`):** a mask built as `(1<<n1)-1` would overflow and corrupt the field.
- **Counts at or above the length:** a design that did not reduce modulo `n1` would clear the field rather than rotate the count.
- **Counts that are exact multiples of `n1`:** these must leave both data and carry alone. A wrong design would clear the field or update the carry.
- **Lengths just above the device limit and just above `W`:** a design with the checks in the wrong order would report 4101 where 4100 is due.
- **Negative counts:** treating the count as unsigned would shift by a huge amount instead of rejecting the request.
- **Carry bit index:** the expected carry is computed arithmetically for every legal `n1`/`n2` pair, so an off-by-one in the index is exposed.

// File: rtl/shl_pkg.sv
package shl_pkg;

  localparam int unsigned CODE_W = 16;

  localparam logic [CODE_W-1:0] ERR_RANGE = 16'd4100;
  localparam logic [CODE_W-1:0] ERR_SIZE  = 16'd4101;
  localparam logic [CODE_W-1:0] ERR_NONE  = 16'd0;

  typedef enum logic [1:0] {
    OP_SHIFT   = 2'd0,
    OP_NOOP    = 2'd1,
    OP_BAD_ARG = 2'd2,
    OP_BAD_DST = 2'd3
  } op_kind_e;

endpackage

// File: rtl/shl_decode.sv
module shl_decode
  import shl_pkg::*;
#(
  parameter int unsigned W   = 64,
  parameter int unsigned N1W = 8,
  parameter int unsigned N2W = 16,
  parameter int unsigned SW  = $clog2(W) + 1
) (
  input  logic [N1W-1:0]        n1,
  input  logic signed [N2W-1:0] n2,
  input  logic [N1W-1:0]        dst_bits,
  output op_kind_e              kind,
  output logic [SW-1:0]         shamt
);

  localparam logic [N1W:0] W_EXT = (N1W+1)'(W);

  logic          len_big;
  logic          cnt_neg;
  logic          dst_short;
  logic          len_zero;
  logic          cnt_zero;
  logic [N2W-1:0] cnt_mag;
  logic [N2W-1:0] divisor;
  logic [N2W-1:0] rem;

  always_comb begin
    len_big   = {1'b0, n1} > W_EXT;
    cnt_neg   = n2[N2W-1];
    dst_short = n1 > dst_bits;
    len_zero  = (n1 == '0);
    cnt_zero  = (n2 == '0);
    cnt_mag   = n2;
    divisor   = len_zero ? N2W'(1) : N2W'(n1);
    rem       = cnt_mag % divisor;
    shamt     = rem[SW-1:0];

    if (len_big || cnt_neg)                  kind = OP_BAD_ARG;
    else if (dst_short)                      kind = OP_BAD_DST;
    else if (len_zero || cnt_zero || rem == '0) kind = OP_NOOP;
    else                                     kind = OP_SHIFT;
  end

endmodule

// File: rtl/shl_field.sv
module shl_field #(
  parameter int unsigned W  = 64,
  parameter int unsigned SW = $clog2(W) + 1
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] len,
  input  logic [SW-1:0] shamt,
  output logic [W-1:0]  dout,
  output logic          cout
);

  logic [W-1:0]  in_field;
  logic [W-1:0]  out_sel;
  logic [W-1:0]  moved;
  logic [SW-1:0] exit_idx;

  assign exit_idx = len - shamt;
  assign moved    = din << shamt;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign in_field[i] = (SW'(i) < len);
    assign out_sel[i]  = (SW'(i) == exit_idx);
  end

  assign dout = (moved & in_field) | (din & ~in_field);
  assign cout = |(din & out_sel);

endmodule

// File: rtl/shl_bitfield_carry.sv
module shl_bitfield_carry
  import shl_pkg::*;
#(
  parameter int unsigned W   = 64,
  parameter int unsigned N1W = 8,
  parameter int unsigned N2W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [W-1:0]          din,
  input  logic [N1W-1:0]        n1,
  input  logic signed [N2W-1:0] n2,
  input  logic [N1W-1:0]        dst_bits,
  output logic [W-1:0]          dout,
  output logic                  carry,
  output logic                  done,
  output logic                  err,
  output logic [CODE_W-1:0]     err_code
);

  localparam int unsigned SW = $clog2(W) + 1;

  op_kind_e      kind;
  logic [SW-1:0] shamt;
  logic [W-1:0]  shifted;
  logic          shift_cout;

  shl_decode #(.W(W), .N1W(N1W), .N2W(N2W), .SW(SW)) u_decode (
    .n1       (n1),
    .n2       (n2),
    .dst_bits (dst_bits),
    .kind     (kind),
    .shamt    (shamt)
  );

  shl_field #(.W(W), .SW(SW)) u_field (
    .din   (din),
    .len   (n1[SW-1:0]),
    .shamt (shamt),
    .dout  (shifted),
    .cout  (shift_cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout     <= '0;
      carry    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      done <= start;
      if (start) begin
        unique case (kind)
          OP_SHIFT: begin
            dout     <= shifted;
            carry    <= shift_cout;
            err      <= 1'b0;
            err_code <= ERR_NONE;
          end
          OP_NOOP: begin
            dout     <= din;
            err      <= 1'b0;
            err_code <= ERR_NONE;
          end
          OP_BAD_ARG: begin
            dout     <= din;
            err      <= 1'b1;
            err_code <= ERR_RANGE;
          end
          OP_BAD_DST: begin
            dout     <= din;
            err      <= 1'b1;
            err_code <= ERR_SIZE;
          end
          default: begin
            dout     <= din;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/shl_bitfield_carry_chk.sv
module shl_bitfield_carry_chk
  import shl_pkg::*;
#(
  parameter int unsigned W   = 64,
  parameter int unsigned N1W = 8,
  parameter int unsigned N2W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  start,
  input logic [W-1:0]          din,
  input logic [N1W-1:0]        n1,
  input logic signed [N2W-1:0] n2,
  input logic [N1W-1:0]        dst_bits,
  input logic [W-1:0]          dout,
  input logic                  carry,
  input logic                  done,
  input logic                  err,
  input logic [CODE_W-1:0]     err_code
);

  p_done_follows_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  p_done_cause_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start));

  p_negative_count_r1: assert property (@(posedge clk) disable iff (rst)
    start && n2[N2W-1] |=> err && err_code == ERR_RANGE);

  p_err_code_valid_r2: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_code == ERR_RANGE || err_code == ERR_SIZE));

  p_zero_count_carry_r3: assert property (@(posedge clk) disable iff (rst)
    start && n2 == '0 |=> $stable(carry));

  p_upper_pass_r6: assert property (@(posedge clk) disable iff (rst)
    start |=> ((dout ^ $past(din)) >> $past(n1)) == '0);

  p_code_clear_r10: assert property (@(posedge clk) disable iff (rst)
    done && !err |-> err_code == ERR_NONE);

endmodule

bind shl_bitfield_carry shl_bitfield_carry_chk #(.W(W), .N1W(N1W), .N2W(N2W)) u_chk (.*);

// File: tb/tb_shl_bitfield_carry.sv
module tb_shl_bitfield_carry;

  localparam int W   = 8;
  localparam int N1W = 8;
  localparam int N2W = 16;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic                  start = 1'b0;
  logic [W-1:0]          din = '0;
  logic [N1W-1:0]        n1 = '0;
  logic signed [N2W-1:0] n2 = '0;
  logic [N1W-1:0]        dst_bits = '0;
  logic [W-1:0]          dout;
  logic                  carry;
  logic                  done;
  logic                  err;
  logic [15:0]           err_code;

  int n_run  = 0;
  int n_fail = 0;
  logic exp_carry = 1'b0;

  always #5 clk = ~clk;

  shl_bitfield_carry #(.W(W), .N1W(N1W), .N2W(N2W)) dut (
    .clk(clk), .rst(rst), .start(start), .din(din), .n1(n1), .n2(n2),
    .dst_bits(dst_bits), .dout(dout), .carry(carry), .done(done),
    .err(err), .err_code(err_code)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_op(input int l, input int c, input int d, input int lim);
    longint lowp, newlow, upper, exp_d;
    int s, kind, exp_code;
    string tag;
    @(negedge clk);
    din = W'(d); n1 = N1W'(l); n2 = N2W'(c); dst_bits = N1W'(lim); start = 1'b1;
    // kind: 0 shift, 1 noop, 2 range error, 3 size error
    s = 0;
    if (l > W || c < 0)       begin kind = 2; exp_code = 4100; tag = "R1"; end
    else if (l > lim)         begin kind = 3; exp_code = 4101; tag = "R2"; end
    else if (l == 0 || c == 0) begin kind = 1; exp_code = 0; tag = "R3"; end
    else begin
      s = c % l;
      exp_code = 0;
      if (s == 0) begin kind = 1; tag = "R4"; end
      else        begin kind = 0; tag = "R5"; end
    end
    if (kind == 0) begin
      lowp   = longint'(d) % (64'sd1 << l);
      newlow = (lowp << s) % (64'sd1 << l);
      upper  = longint'(d) - lowp;
      exp_d  = upper + newlow;
      exp_carry = ((longint'(d) >> (l - s)) & 1) != 0;
    end else begin
      exp_d = longint'(d);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R8 done pulse", longint'(done), 1);
    chk(longint'(dout) == exp_d, tag, longint'(dout), exp_d);
    if (l <= W)
      chk((longint'(dout) >> l) == (longint'(d) >> l), "R6 upper bits", longint'(dout) >> l, longint'(d) >> l);
    chk(carry == exp_carry, (kind == 0) ? "R7 carry" : "R3 carry held", longint'(carry), longint'(exp_carry));
    chk(err == (kind >= 2), (kind >= 2) ? tag : "R10 err", longint'(err), longint'(kind >= 2));
    chk(longint'(err_code) == longint'(exp_code), (kind >= 2) ? tag : "R10 code", longint'(err_code), longint'(exp_code));
    @(negedge clk);
    chk(done == 1'b0, "R8 done single", longint'(done), 0);
  endtask

  initial begin
    int pats[4] = '{8'hA5, 8'h3C, 8'hFF, 8'h81};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dout == '0 && carry == 1'b0 && done == 1'b0 && err == 1'b0 && err_code == '0,
        "R9 reset", longint'(dout), 0);
    for (int li = 0; li < 2; li++) begin
      for (int l = 0; l <= W + 2; l++) begin
        for (int c = -2; c <= 19; c++) begin
          for (int p = 0; p < 4; p++) begin
            run_op(l, c, pats[p], (li == 0) ? W : 5);
          end
        end
      end
    end
    // exact multiple with carry primed high: carry must hold (R4)
    run_op(W, 3, 8'h20, W);
    run_op(4, 8, 8'h0F, W);
    // range error beats size error (R1 over R2)
    run_op(W + 1, 1, 8'h55, 3);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule